// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen architectural 32-bit general registers of a processor core that runs in several operating modes. Some register numbers name different physical words depending on the mode in force. The lower eight are one copy that every mode sees. Registers 8 to 12 get a private set in the fast-interrupt mode only. Registers 13 and 14, the stack pointer and link register, get a private pair in each mode entered through an exception. The block turns a register number and a mode into one physical word and stores the data. Register 15 is handled elsewhere, so the block does not store it.

The block has two combinational read ports and one write port that updates on the clock edge. All three ports share one mode input. An override input maps every access to the user-mode copies, so a privileged handler can save or restore a user context. Instruction decode, status registers and exception entry sequencing sit outside the block.

Top module: `banked_regfile`

## Requirements
- R1: Registers 0 to 7 are a single copy. A value written in any mode reads back unchanged in every other mode.
- R2: Registers 8 to 12 have one private set, used only when the mode code is 10001 (fast interrupt) and the override is low. Every other mode reads and writes the shared set.
- R3: Registers 13 and 14 have a private pair for each exception mode. The codes are 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort and 11011 undefined. A write in one of these modes is not visible in any other mode.
- R4: Mode code 10000 (user), code 11111 (system) and every code not listed in R3 all use the user copies of registers 8 to 14.
- R5: While the override input `usr_view_i` is 1, reads and writes reach the user copies whatever the mode code.
- R6: A write with `wr_en_i` = 1 changes only the one physical word selected by the write number, the mode and the override. A read of that word in the next cycle returns the written data.
- R7: A read of a register in the same cycle as a write to it returns the value held before the clock edge.
- R8: A read of register 15 returns zero. A write to register 15 changes no stored word.
- R9: While reset is low, every stored word is cleared to zero.
- R10: The two read ports resolve their register numbers independently under the shared mode and override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current operating-mode code |
| usr_view_i | input | 1 | Force all accesses onto the user copies |
| rda_idx_i | input | 4 | Register number for read port A |
| rda_data_o | output | 32 | Read port A data |
| rdb_idx_i | input | 4 | Register number for read port B |
| rdb_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Register number for the write |
| wr_data_i | input | 32 | Write data |

## Verification
The hardest case to reach from the ports is an aliasing error. This is a write in one mode that lands in a word belonging to another bank. It shows up only when the same register number is later read in the other mode before it is overwritten. The bench therefore fills registers 0 to 14 with a distinct value in every mode code, including an unlisted one, in a fixed sweep. It then reads every register under every mode and under the override, against a model that keeps separate words per bank. After that, a seeded random phase mixes writes and reads across modes and the override with short gaps, so stale or leaked values surface on both ports.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int IDX_W       = 4;
    localparam int MODE_W      = 5;
    localparam int DATA_W      = 32;

    // Physical layout: user words for registers 0..14, then the fast-interrupt
    // set for 8..12, then one stack/link pair per exception bank.
    localparam int USR_WORDS   = 15;
    localparam int FIQ_WORDS   = 5;
    localparam int EXC_BANKS   = 5;
    localparam int PAIR_WORDS  = 2;
    localparam int PHYS_WORDS  = USR_WORDS + FIQ_WORDS + EXC_BANKS * PAIR_WORDS;
    localparam int PHYS_W      = $clog2(PHYS_WORDS);

    localparam logic [IDX_W-1:0] FIQ_FIRST = 4'd8;
    localparam logic [IDX_W-1:0] FIQ_LAST  = 4'd12;
    localparam logic [IDX_W-1:0] SP_IDX    = 4'd13;
    localparam logic [IDX_W-1:0] LR_IDX    = 4'd14;
    localparam logic [IDX_W-1:0] PC_IDX    = 4'd15;

    localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    typedef struct packed {
        logic [PHYS_W-1:0] phys;
        logic              hit;
    } map_t;

endpackage

// File: rtl/rf_bank_decode.sv
module rf_bank_decode
    import rf_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic              usr_view_i,
    output bank_e             bank_o
);

    bank_e bank_raw;

    always_comb begin
        unique case (mode_i)
            MD_FIQ:  bank_raw = BK_FIQ;
            MD_IRQ:  bank_raw = BK_IRQ;
            MD_SVC:  bank_raw = BK_SVC;
            MD_ABT:  bank_raw = BK_ABT;
            MD_UND:  bank_raw = BK_UND;
            default: bank_raw = BK_USR;
        endcase
    end

    assign bank_o = usr_view_i ? BK_USR : bank_raw;

endmodule

// File: rtl/rf_addr_map.sv
module rf_addr_map
    import rf_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    input  bank_e            bank_i,
    output map_t             map_o
);

    localparam int FIQ_BASE = USR_WORDS;
    localparam int EXC_BASE = USR_WORDS + FIQ_WORDS;

    logic in_fiq_range;
    logic in_pair_range;

    assign in_fiq_range  = (idx_i >= FIQ_FIRST) && (idx_i <= FIQ_LAST);
    assign in_pair_range = (idx_i == SP_IDX) || (idx_i == LR_IDX);

    always_comb begin
        map_o.hit  = (idx_i != PC_IDX);
        map_o.phys = PHYS_W'(idx_i);
        if (in_fiq_range && bank_i == BK_FIQ) begin
            map_o.phys = PHYS_W'(FIQ_BASE + int'(idx_i) - int'(FIQ_FIRST));
        end else if (in_pair_range && bank_i != BK_USR) begin
            map_o.phys = PHYS_W'(EXC_BASE
                                 + (int'(bank_i) - 1) * PAIR_WORDS
                                 + int'(idx_i) - int'(SP_IDX));
        end
    end

endmodule

// File: rtl/rf_store.sv
module rf_store
    import rf_pkg::*;
#(
    parameter int DEPTH  = PHYS_WORDS,
    parameter int WIDTH  = DATA_W,
    parameter int NRD    = 2,
    parameter int AW     = PHYS_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic                       wr_hit_i,
    input  logic [AW-1:0]              wr_phys_i,
    input  logic [WIDTH-1:0]           wr_data_i,
    input  logic [NRD-1:0]             rd_hit_i,
    input  logic [NRD-1:0][AW-1:0]     rd_phys_i,
    output logic [NRD-1:0][WIDTH-1:0]  rd_data_o
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] words;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && wr_hit_i) begin
            st_d.words[wr_phys_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data_o[p] = rd_hit_i[p] ? st_q.words[rd_phys_i[p]] : '0;
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic              usr_view_i,
    input  logic [3:0]        rda_idx_i,
    output logic [31:0]       rda_data_o,
    input  logic [3:0]        rdb_idx_i,
    output logic [31:0]       rdb_data_o,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [31:0]       wr_data_i
);

    localparam int NRD   = 2;
    localparam int NPORT = NRD + 1;
    localparam int WR_P  = NRD;

    bank_e                         bank;
    logic [NPORT-1:0][IDX_W-1:0]   port_idx;
    map_t [NPORT-1:0]              port_map;
    logic [NRD-1:0]                rd_hit;
    logic [NRD-1:0][PHYS_W-1:0]    rd_phys;
    logic [NRD-1:0][DATA_W-1:0]    rd_data;

    rf_bank_decode u_dec (
        .mode_i     (mode_i),
        .usr_view_i (usr_view_i),
        .bank_o     (bank)
    );

    assign port_idx[0]    = rda_idx_i;
    assign port_idx[1]    = rdb_idx_i;
    assign port_idx[WR_P] = wr_idx_i;

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rf_addr_map u_map (
            .idx_i  (port_idx[p]),
            .bank_i (bank),
            .map_o  (port_map[p])
        );
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rdsel
        assign rd_hit[p]  = port_map[p].hit;
        assign rd_phys[p] = port_map[p].phys;
    end

    rf_store #(
        .DEPTH (PHYS_WORDS),
        .WIDTH (DATA_W),
        .NRD   (NRD),
        .AW    (PHYS_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_hit_i  (port_map[WR_P].hit),
        .wr_phys_i (port_map[WR_P].phys),
        .wr_data_i (wr_data_i),
        .rd_hit_i  (rd_hit),
        .rd_phys_i (rd_phys),
        .rd_data_o (rd_data)
    );

    assign rda_data_o = rd_data[0];
    assign rdb_data_o = rd_data[1];

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  mode_i,
    input  logic        usr_view_i,
    input  logic [3:0]  rda_idx_i,
    input  logic [31:0] rda_data_o,
    input  logic [3:0]  rdb_idx_i,
    input  logic [31:0] rdb_data_o,
    input  logic        wr_en_i,
    input  logic [3:0]  wr_idx_i,
    input  logic [31:0] wr_data_i
);

    logic fiq_eff;
    logic usr_eq;
    logic a_mid;
    logic a_pair;

    assign fiq_eff = (mode_i == 5'b10001) && !usr_view_i;
    assign usr_eq  = usr_view_i ||
                     !(mode_i == 5'b10001 || mode_i == 5'b10010 || mode_i == 5'b10011 ||
                       mode_i == 5'b10111 || mode_i == 5'b11011);
    assign a_mid   = (rda_idx_i >= 4'd8) && (rda_idx_i <= 4'd12);
    assign a_pair  = (rda_idx_i == 4'd13) || (rda_idx_i == 4'd14);

    AST_PC_READ_A_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rda_idx_i == 4'hF) |-> (rda_data_o == 32'h0)); // R8

    AST_PC_READ_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdb_idx_i == 4'hF) |-> (rdb_data_o == 32'h0)); // R10

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i != 4'hF) |=>
        ((rda_idx_i != $past(wr_idx_i)) || (mode_i != $past(mode_i)) ||
         (usr_view_i != $past(usr_view_i)) || (rda_data_o == $past(wr_data_i)))); // R6

    AST_LOW_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && rda_idx_i < 4'd8) |=>
        ((rda_idx_i != $past(rda_idx_i)) || (rda_data_o == $past(rda_data_o)))); // R1

    AST_MID_OUTSIDE_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && a_mid && !fiq_eff) |=>
        ((rda_idx_i != $past(rda_idx_i)) || fiq_eff ||
         (rda_data_o == $past(rda_data_o)))); // R2

    AST_SYS_SHARES_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && a_pair && usr_eq) |=>
        ((rda_idx_i != $past(rda_idx_i)) || !usr_eq ||
         (rda_data_o == $past(rda_data_o)))); // R4

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEARS: assert (rda_data_o == 32'h0 && rdb_data_o == 32'h0); // R9
        end
    end

endmodule

bind banked_regfile banked_regfile_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .usr_view_i (usr_view_i),
    .rda_idx_i  (rda_idx_i),
    .rda_data_o (rda_data_o),
    .rdb_idx_i  (rdb_idx_i),
    .rdb_data_o (rdb_data_o),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_data_i  (wr_data_i)
);

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = 5'b10000;
    logic        usr_view_i = 1'b0;
    logic [3:0]  rda_idx_i = '0;
    logic [3:0]  rdb_idx_i = '0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_idx_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rda_data_o;
    logic [31:0] rdb_data_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model [96];

    logic [4:0] modes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                              5'b10111, 5'b11011, 5'b11111, 5'b00110};

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .usr_view_i (usr_view_i),
        .rda_idx_i  (rda_idx_i),
        .rda_data_o (rda_data_o),
        .rdb_idx_i  (rdb_idx_i),
        .rdb_data_o (rdb_data_o),
        .wr_en_i    (wr_en_i),
        .wr_idx_i   (wr_idx_i),
        .wr_data_i  (wr_data_i)
    );

    // Bank number from the requirements: 0 user, 1..5 the exception modes.
    function automatic int bank_of(logic [4:0] m, logic uv);
        if (uv) return 0;
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    // Model slot: bank*16+idx after folding shared registers onto bank 0.
    function automatic int slot_of(logic [3:0] idx, logic [4:0] m, logic uv);
        int b;
        b = bank_of(m, uv);
        if (idx == 4'd15) return -1;
        if (idx < 4'd8) b = 0;
        else if (idx <= 4'd12 && b != 1) b = 0;
        return b * 16 + int'(idx);
    endfunction

    function automatic logic [31:0] expect_rd(logic [3:0] idx, logic [4:0] m, logic uv);
        int s;
        s = slot_of(idx, m, uv);
        return (s < 0) ? 32'h0 : model[s];
    endfunction

    function automatic string tag_of(logic [3:0] idx, logic [4:0] m, logic uv);
        if (idx == 4'd15) return "R8";
        if (uv) return "R5";
        if (idx < 4'd8) return "R1";
        if (idx <= 4'd12) return "R2";
        if (bank_of(m, uv) == 0) return "R4";
        return "R3";
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h (mode %05b uv %0b)",
                     req, got, exp, mode_i, usr_view_i);
        end
    endtask

    // One cycle: drive after the falling edge, compare reads before the
    // rising edge (old contents), then commit the write to the model.
    task automatic cyc(logic [4:0] m, logic uv, logic [3:0] ra, logic [3:0] rb,
                       logic we, logic [3:0] wi, logic [31:0] wd, string tag_b);
        int s;
        @(negedge clk);
        mode_i = m; usr_view_i = uv; rda_idx_i = ra; rdb_idx_i = rb;
        wr_en_i = we; wr_idx_i = wi; wr_data_i = wd;
        #1;
        check(tag_of(ra, m, uv), rda_data_o, expect_rd(ra, m, uv));
        check(tag_b, rdb_data_o, expect_rd(rb, m, uv));
        @(posedge clk);
        if (we) begin
            s = slot_of(wi, m, uv);
            if (s >= 0) model[s] = wd;
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        for (int i = 0; i < 96; i++) model[i] = 32'h0;

        // R9: reset contents are zero on both ports.
        repeat (2) @(negedge clk);
        rda_idx_i = 4'd3; rdb_idx_i = 4'd13; mode_i = 5'b10011;
        #1;
        check("R9", rda_data_o, 32'h0);
        check("R9", rdb_data_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int r = 0; r < 15; r++) begin
            cyc(5'b10001, 1'b0, 4'(r), 4'(14 - r), 1'b0, 4'd0, 32'h0, "R9");
        end

        // Sweep: distinct value per mode and register, then read in all modes.
        for (int k = 0; k < 8; k++) begin
            for (int r = 0; r < 15; r++) begin
                cyc(modes[k], 1'b0, 4'(r), 4'd15, 1'b1, 4'(r),
                    {8'hA0 + 8'(k), 16'h0, 8'(r)}, "R8");
            end
        end
        for (int k = 0; k < 8; k++) begin
            for (int r = 0; r < 16; r++) begin
                cyc(modes[k], 1'b0, 4'(r), 4'(15 - r), 1'b0, 4'd0, 32'h0, "R10");
            end
            for (int r = 0; r < 15; r++) begin
                cyc(modes[k], 1'b1, 4'(r), 4'(r), 1'b0, 4'd0, 32'h0, "R5");
            end
        end

        // R7 then R6: same-cycle read returns old, next cycle returns new.
        cyc(5'b10010, 1'b0, 4'd13, 4'd13, 1'b1, 4'd13, 32'hDEAD_0013, "R7");
        cyc(5'b10010, 1'b0, 4'd13, 4'd13, 1'b0, 4'd0, 32'h0, "R6");
        cyc(5'b10011, 1'b0, 4'd13, 4'd13, 1'b0, 4'd0, 32'h0, "R3");
        cyc(5'b10000, 1'b0, 4'd13, 4'd14, 1'b0, 4'd0, 32'h0, "R4");

        // R8: write to register 15 in several modes, then nothing else moved.
        cyc(5'b10001, 1'b0, 4'd15, 4'd15, 1'b1, 4'd15, 32'hFFFF_FFFF, "R8");
        cyc(5'b10000, 1'b1, 4'd15, 4'd15, 1'b1, 4'd15, 32'h1234_5678, "R8");
        for (int k = 0; k < 8; k++) begin
            for (int r = 0; r < 15; r++) begin
                cyc(modes[k], 1'b0, 4'(r), 4'd15, 1'b0, 4'd0, 32'h0, "R8");
            end
        end

        // R5: override write from supervisor lands in the user stack pointer.
        cyc(5'b10011, 1'b1, 4'd13, 4'd9, 1'b1, 4'd13, 32'h5EC0_0D13, "R5");
        cyc(5'b10000, 1'b0, 4'd13, 4'd13, 1'b0, 4'd0, 32'h0, "R5");
        cyc(5'b10011, 1'b0, 4'd13, 4'd13, 1'b0, 4'd0, 32'h0, "R3");

        // Random mix across modes, override and register numbers.
        for (int n = 0; n < N_RANDOM; n++) begin
            logic [4:0] m;
            m = modes[$urandom_range(7)];
            cyc(m, ($urandom_range(4) == 0), 4'($urandom_range(15)),
                4'($urandom_range(15)), ($urandom_range(2) != 0),
                4'($urandom_range(15)), $urandom(), "R10");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule